// File: doc/BRIEF.md
# Secured OTP Region Access Controller

This block sits behind the command parser of a serial NOR flash front end. It takes one decoded command per cycle: an opcode, a byte address and a data byte. It decides whether ordinary read and program requests go to the main array or to a small one-time-programmable region. An explicit entry command switches the device into OTP mode. Plain read and program commands then reach the OTP storage, and the main array cannot be reached at all. A matching exit command returns to main-array operation.

The OTP region holds 512 bytes and can be locked for good. A lock-down bit is set by a write of the security register that follows a write enable. It is mirrored by an external non-volatile cell, so it survives reset. Once the region is locked, either by that bit or by a factory-lock strap, a program request to it is dropped and a fail flag is raised. Request outputs are registered one cycle after the command. Read data from the selected storage is steered back combinationally in the cycle its read strobe is high.

Top module: `otp_access_ctrl`

## Requirements
- R1: Opcode B1h sets `otp_mode` to 1 and opcode C1h clears it to 0. Both changes are visible in the cycle after the command.
- R2: A read (03h) issued in main mode pulses `main_rd_en` for one cycle. In OTP mode it pulses `otp_rd_en` instead. A program (02h) is routed the same way to `main_wr_en` or `otp_wr_en`. While in OTP mode, `main_rd_en` and `main_wr_en` stay 0.
- R3: `otp_addr` equals the command address modulo 512, so OTP addresses at or above 512 wrap.
- R4: A program or security-register write is accepted only while the write-enable latch is set. Opcode 06h sets the latch and 04h clears it. Any 02h or 2Fh command clears it, whether or not the command was accepted.
- R5: A program to a locked OTP region produces no write strobe and sets `sec_reg` bit 5 (fail). The next accepted program to either storage clears that bit.
- R6: A 2Fh command with the latch set and data bit 1 equal to 1 sets the lock-down bit, `sec_reg` bit 1. It also pulses `lock_pgm` for one cycle. The same command without the latch set has no effect.
- R7: Once set, the lock-down bit stays 1 through a later 2Fh with data bit 1 equal to 0. It also stays 1 through reset while `lock_nv` is held at 1.
- R8: `sec_reg` bit 0 reflects `factory_lock`. A factory-locked OTP region rejects programs exactly as in R5.
- R9: Reset leaves the block in main mode with the write-enable latch, the fail bit and all strobes at 0.
- R10: `rd_data` returns `otp_rdata` while `otp_rd_en` is 1, and `main_rdata` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_op | input | 8 | Opcode |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | 8 | Program or register data byte |
| factory_lock | input | 1 | Factory lock strap for the OTP region |
| lock_nv | input | 1 | Stored state of the non-volatile lock-down cell |
| main_rdata | input | 8 | Read data from main array |
| otp_rdata | input | 8 | Read data from OTP storage |
| main_rd_en | output | 1 | Main array read strobe |
| main_wr_en | output | 1 | Main array program strobe |
| main_addr | output | ADDR_W | Main array address |
| otp_rd_en | output | 1 | OTP read strobe |
| otp_wr_en | output | 1 | OTP program strobe |
| otp_addr | output | 9 | OTP byte address |
| wdata | output | 8 | Program data to either storage |
| lock_pgm | output | 1 | One-cycle request to set the non-volatile lock cell |
| rd_data | output | 8 | Read data returned to the parser |
| otp_mode | output | 1 | 1 while OTP mode is active |
| sec_reg | output | 8 | Security register: bit0 factory lock, bit1 lock-down, bit5 program fail |

## Verification
The hardest state to reach is a lock that outlives a reset. The internal copy of the lock is cleared by reset, so only the external cell keeps the region closed. To get there, the bench models that cell and sets it from `lock_pgm`. It then pulses reset and re-enters OTP mode. A program issued at that point must still be refused, and the stored byte must read back unchanged. The factory strap gets its own pass before the lock-down bit is ever set.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_ENTER  = 8'hB1;
  localparam logic [7:0] OP_EXIT   = 8'hC1;
  localparam logic [7:0] OP_WRSEC  = 8'h2F;
  localparam int         SEC_FACT  = 0;
  localparam int         SEC_LOCK  = 1;
  localparam int         SEC_FAIL  = 5;
endpackage

// File: rtl/otp_mode_ctl.sv
module otp_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_i,
  input  logic exit_i,
  input  logic wren_i,
  input  logic wrdi_i,
  input  logic consume_i,
  output logic mode_o,
  output logic wel_o
);
  logic mode_q, mode_d, wel_q, wel_d;

  always_comb begin
    mode_d = mode_q;
    if (enter_i)     mode_d = 1'b1;
    else if (exit_i) mode_d = 1'b0;
    wel_d = wel_q;
    if (wren_i)                      wel_d = 1'b1;
    else if (wrdi_i || consume_i)    wel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      wel_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      wel_q  <= wel_d;
    end
  end

  assign mode_o = mode_q;
  assign wel_o  = wel_q;
endmodule

// File: rtl/otp_lock_ctl.sv
module otp_lock_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_req_i,
  input  logic pgm_ok_i,
  input  logic pgm_blk_i,
  input  logic lock_nv_i,
  output logic lockdown_o,
  output logic fail_o,
  output logic lock_pgm_o
);
  logic lock_q, lock_d, fail_q, fail_d, pgm_q;

  always_comb begin
    lock_d = lock_q | lock_req_i;
    fail_d = fail_q;
    if (pgm_blk_i)     fail_d = 1'b1;
    else if (pgm_ok_i) fail_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      fail_q <= 1'b0;
      pgm_q  <= 1'b0;
    end else begin
      lock_q <= lock_d;
      fail_q <= fail_d;
      pgm_q  <= lock_req_i;
    end
  end

  assign lockdown_o = lock_q | lock_nv_i;
  assign fail_o     = fail_q;
  assign lock_pgm_o = pgm_q;
endmodule

// File: rtl/otp_router.sv
module otp_router #(
  parameter int ADDR_W = 24,
  parameter int OTP_AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic              rd_req_i,
  input  logic              mode_i,
  input  logic              main_wr_ok_i,
  input  logic              otp_wr_ok_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              main_rd_o,
  output logic              main_wr_o,
  output logic              otp_rd_o,
  output logic              otp_wr_o,
  output logic [ADDR_W-1:0] main_addr_o,
  output logic [OTP_AW-1:0] otp_addr_o,
  output logic [7:0]        data_o
);
  logic main_rd_d, main_wr_d, otp_rd_d, otp_wr_d;
  logic main_rd_q, main_wr_q, otp_rd_q, otp_wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;

  always_comb begin
    main_rd_d = rd_req_i & ~mode_i;
    otp_rd_d  = rd_req_i &  mode_i;
    main_wr_d = main_wr_ok_i;
    otp_wr_d  = otp_wr_ok_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_rd_q <= 1'b0;
      main_wr_q <= 1'b0;
      otp_rd_q  <= 1'b0;
      otp_wr_q  <= 1'b0;
    end else begin
      main_rd_q <= main_rd_d;
      main_wr_q <= main_wr_d;
      otp_rd_q  <= otp_rd_d;
      otp_wr_q  <= otp_wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cmd_valid_i) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  assign main_rd_o   = main_rd_q;
  assign main_wr_o   = main_wr_q;
  assign otp_rd_o    = otp_rd_q;
  assign otp_wr_o    = otp_wr_q;
  assign main_addr_o = addr_q;
  assign otp_addr_o  = addr_q[OTP_AW-1:0];
  assign data_o      = data_q;
endmodule

// File: rtl/otp_access_ctrl.sv
module otp_access_ctrl #(
  parameter int ADDR_W    = 24,
  parameter int OTP_BYTES = 512,
  localparam int OTP_AW   = $clog2(OTP_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  input  logic              factory_lock,
  input  logic              lock_nv,
  input  logic [7:0]        main_rdata,
  input  logic [7:0]        otp_rdata,
  output logic              main_rd_en,
  output logic              main_wr_en,
  output logic [ADDR_W-1:0] main_addr,
  output logic              otp_rd_en,
  output logic              otp_wr_en,
  output logic [OTP_AW-1:0] otp_addr,
  output logic [7:0]        wdata,
  output logic              lock_pgm,
  output logic [7:0]        rd_data,
  output logic              otp_mode,
  output logic [7:0]        sec_reg
);
  import otp_pkg::*;

  logic mode, wel, lockdown, fail, locked;
  logic is_rd, is_pg, is_wren, is_wrdi, is_ent, is_ext, is_wsec;
  logic pgm_req, pgm_main_ok, pgm_otp_ok, pgm_blk, lock_req, consume;

  always_comb begin
    is_rd   = cmd_valid && (cmd_op == OP_READ);
    is_pg   = cmd_valid && (cmd_op == OP_PROG);
    is_wren = cmd_valid && (cmd_op == OP_WREN);
    is_wrdi = cmd_valid && (cmd_op == OP_WRDI);
    is_ent  = cmd_valid && (cmd_op == OP_ENTER);
    is_ext  = cmd_valid && (cmd_op == OP_EXIT);
    is_wsec = cmd_valid && (cmd_op == OP_WRSEC);
    locked      = lockdown | factory_lock;
    pgm_req     = is_pg & wel;
    pgm_main_ok = pgm_req & ~mode;
    pgm_otp_ok  = pgm_req &  mode & ~locked;
    pgm_blk     = pgm_req &  mode &  locked;
    lock_req    = is_wsec & wel & cmd_wdata[SEC_LOCK];
    consume     = is_pg | is_wsec;
  end

  otp_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .enter_i(is_ent), .exit_i(is_ext),
    .wren_i(is_wren), .wrdi_i(is_wrdi), .consume_i(consume),
    .mode_o(mode), .wel_o(wel)
  );

  otp_lock_ctl u_lock (
    .clk(clk), .rst_n(rst_n), .lock_req_i(lock_req),
    .pgm_ok_i(pgm_main_ok | pgm_otp_ok), .pgm_blk_i(pgm_blk),
    .lock_nv_i(lock_nv), .lockdown_o(lockdown), .fail_o(fail),
    .lock_pgm_o(lock_pgm)
  );

  otp_router #(.ADDR_W(ADDR_W), .OTP_AW(OTP_AW)) u_route (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .rd_req_i(is_rd),
    .mode_i(mode), .main_wr_ok_i(pgm_main_ok), .otp_wr_ok_i(pgm_otp_ok),
    .addr_i(cmd_addr), .data_i(cmd_wdata),
    .main_rd_o(main_rd_en), .main_wr_o(main_wr_en), .otp_rd_o(otp_rd_en),
    .otp_wr_o(otp_wr_en), .main_addr_o(main_addr), .otp_addr_o(otp_addr),
    .data_o(wdata)
  );

  always_comb begin
    rd_data = otp_rd_en ? otp_rdata : main_rdata;
    sec_reg = 8'h00;
    sec_reg[SEC_FACT] = factory_lock;
    sec_reg[SEC_LOCK] = lockdown;
    sec_reg[SEC_FAIL] = fail;
  end

  assign otp_mode = mode;
endmodule

// File: rtl/otp_access_chk.sv
module otp_access_chk #(
  parameter int ADDR_W = 24,
  parameter int OTP_AW = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              main_rd_en,
  input logic              main_wr_en,
  input logic              otp_rd_en,
  input logic              otp_wr_en,
  input logic [OTP_AW-1:0] otp_addr,
  input logic              otp_mode,
  input logic [7:0]        sec_reg
);
  logic seen_clk;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_clk <= 1'b0;
    else        seen_clk <= 1'b1;
  end

  AST_MAIN_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (main_rd_en || main_wr_en) |-> !otp_mode); // R2
  AST_OTP_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (otp_rd_en || otp_wr_en) |-> otp_mode); // R2
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({main_rd_en, main_wr_en, otp_rd_en, otp_wr_en})); // R2
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_clk && (otp_rd_en || otp_wr_en)) |-> otp_addr == $past(cmd_addr[OTP_AW-1:0])); // R3
  AST_NO_LOCKED_PGM: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_clk && otp_wr_en) |-> $past(sec_reg[1:0] == 2'b00)); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_clk && $past(sec_reg[1])) |-> sec_reg[1]); // R7

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_MAIN: assert (!otp_mode && !otp_wr_en && !main_wr_en); // R9
    end
  end
endmodule

bind otp_access_ctrl otp_access_chk #(.ADDR_W(ADDR_W), .OTP_AW(OTP_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_addr(cmd_addr), .main_rd_en(main_rd_en),
  .main_wr_en(main_wr_en), .otp_rd_en(otp_rd_en), .otp_wr_en(otp_wr_en),
  .otp_addr(otp_addr), .otp_mode(otp_mode), .sec_reg(sec_reg)
);

// File: tb/sim_otp_access_ctrl.sv
`timescale 1ns/1ps
module sim_otp_access_ctrl;
  localparam int AW = 24;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_op = 8'h00;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = 8'h00;
  logic factory_lock = 1'b0;
  logic lock_nv = 1'b0;
  logic [7:0] main_rdata, otp_rdata;
  logic main_rd_en, main_wr_en, otp_rd_en, otp_wr_en, lock_pgm, otp_mode;
  logic [AW-1:0] main_addr;
  logic [8:0] otp_addr;
  logic [7:0] wdata, rd_data, sec_reg;
  logic [7:0] main_mem [256];
  logic [7:0] otp_mem [512];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  otp_access_ctrl u0 (.*);

  assign main_rdata = main_mem[main_addr[7:0]];
  assign otp_rdata  = otp_mem[otp_addr];

  always @(posedge clk) begin
    if (main_wr_en) main_mem[main_addr[7:0]] <= wdata;
    if (otp_wr_en)  otp_mem[otp_addr] <= wdata;
    if (lock_pgm)   lock_nv <= 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] op, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    cmd(8'h06, '0, 8'h00);
    cmd(8'h02, a, d);
  endtask

  task automatic t_reset;
    chk(otp_mode == 0 && sec_reg == 8'h00, "R9 reset state", sec_reg, 0);
    chk(!main_wr_en && !otp_wr_en && !lock_pgm, "R9 strobes idle", otp_wr_en, 0);
  endtask

  task automatic t_mode;
    cmd(8'hB1, '0, 8'h00);
    chk(otp_mode == 1, "R1 enter", otp_mode, 1);
    cmd(8'hC1, '0, 8'h00);
    chk(otp_mode == 0, "R1 exit", otp_mode, 0);
  endtask

  task automatic t_route_main;
    cmd(8'h03, 24'h000042, 8'h00);
    chk(main_rd_en && !otp_rd_en, "R2 main read strobe", main_rd_en, 1);
    chk(rd_data == (8'h42 ^ 8'h3C), "R10 main read data", rd_data, 8'h42 ^ 8'h3C);
    prog(24'h000010, 8'h77);
    chk(main_wr_en && !otp_wr_en && wdata == 8'h77, "R2 main program", main_wr_en, 1);
  endtask

  task automatic t_otp_wrap;
    cmd(8'hB1, '0, 8'h00);
    prog(24'h000005, 8'hA5);
    chk(otp_wr_en && !main_wr_en && otp_addr == 9'd5, "R2 otp program", otp_addr, 5);
    cmd(8'h03, 24'h000205, 8'h00);
    chk(otp_rd_en && !main_rd_en, "R2 main hidden on read", main_rd_en, 0);
    chk(otp_addr == 9'd5, "R3 address wrap", otp_addr, 5);
    chk(rd_data == 8'hA5, "R10 otp read data", rd_data, 8'hA5);
  endtask

  task automatic t_wel;
    cmd(8'h02, 24'h000006, 8'h11);
    chk(!otp_wr_en, "R4 program without enable", otp_wr_en, 0);
    cmd(8'h06, '0, 8'h00);
    cmd(8'h04, '0, 8'h00);
    cmd(8'h02, 24'h000006, 8'h11);
    chk(!otp_wr_en, "R4 enable cleared by 04h", otp_wr_en, 0);
    prog(24'h000006, 8'h22);
    cmd(8'h02, 24'h000007, 8'h33);
    chk(!otp_wr_en, "R4 enable consumed", otp_wr_en, 0);
    cmd(8'h2F, '0, 8'h02);
    chk(sec_reg[1] == 0 && !lock_pgm, "R6 lock without enable ignored", sec_reg, 0);
  endtask

  task automatic t_factory;
    factory_lock = 1'b1;
    prog(24'h000005, 8'h5A);
    chk(!otp_wr_en, "R8 factory lock blocks", otp_wr_en, 0);
    chk(sec_reg[0] && sec_reg[5], "R8 factory bit and fail", sec_reg, 8'h21);
    factory_lock = 1'b0;
    prog(24'h000008, 8'h44);
    chk(otp_wr_en && sec_reg[5] == 0, "R5 fail cleared by accepted program", sec_reg, 0);
  endtask

  task automatic t_lock;
    cmd(8'h06, '0, 8'h00);
    cmd(8'h2F, '0, 8'h02);
    chk(sec_reg[1] == 1, "R6 lock-down set", sec_reg, 2);
    chk(lock_pgm == 1, "R6 lock cell pulse", lock_pgm, 1);
    prog(24'h000005, 8'h99);
    chk(!otp_wr_en && sec_reg[5] == 1, "R5 locked program dropped", sec_reg, 8'h22);
    cmd(8'h03, 24'h000005, 8'h00);
    chk(rd_data == 8'hA5, "R5 otp byte unchanged", rd_data, 8'hA5);
    cmd(8'h06, '0, 8'h00);
    cmd(8'h2F, '0, 8'h00);
    chk(sec_reg[1] == 1, "R7 lock not cleared by write", sec_reg, 2);
  endtask

  task automatic t_persist;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk(otp_mode == 0 && sec_reg == 8'h02, "R9 reset to main mode, fail cleared", sec_reg, 2);
    chk(sec_reg[1] == 1, "R7 lock survives reset", sec_reg, 2);
    cmd(8'hB1, '0, 8'h00);
    prog(24'h000005, 8'h66);
    chk(!otp_wr_en && sec_reg[5], "R7 locked after reset", otp_wr_en, 0);
    cmd(8'h03, 24'h000005, 8'h00);
    chk(rd_data == 8'hA5, "R7 data kept", rd_data, 8'hA5);
    cmd(8'hC1, '0, 8'h00);
    prog(24'h000011, 8'h12);
    chk(main_wr_en && sec_reg[5] == 0, "R5 main program clears fail", sec_reg, 2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) main_mem[i] = 8'(i) ^ 8'h3C;
    for (int i = 0; i < 512; i++) otp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode();
    t_route_main();
    t_otp_wrap();
    t_wel();
    t_factory();
    t_lock();
    t_persist();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule